// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Unit

This block computes either the unsigned product or the unsigned quotient and remainder of two bytes. It works one bit per clock: shift-and-add for the product, and restoring shift-and-subtract for the division. A client presents an operation select and two operand bytes with a one-cycle `start`. The unit raises `busy` for eight cycles and then pulses `done` while it loads a pair of result bytes and two flags.

The results follow an accumulator/B-register convention. For a product, the low byte lands on `res_a` and the high byte on `res_b`. For a quotient, `res_a` carries the quotient and `res_b` the remainder. A zero divisor skips the iterations. The unit then signals overflow and returns a fixed all-ones pattern, so the client always sees a known value.

Top module: `byte_muldiv`

## Requirements
- R1: After reset `busy`, `done`, `cy` and `ov` are 0 and both result bytes are 00h.
- R2: With `op_div`=0 (multiply), the unsigned 16-bit product of `a_in` and `b_in` appears with its low byte on `res_a` and its high byte on `res_b`; for example 55h times 17h yields `res_b`=07h, `res_a`=A3h.
- R3: After a multiply, `ov` is 1 exactly when the product is greater than FFh, and `cy` is 0.
- R4: A `start` sampled while idle raises `busy` from the next cycle for exactly 8 cycles. `done` is then high for one cycle, the first cycle with `busy` low, and the results are valid in that cycle.
- R5: With `op_div`=1 (divide) and a nonzero `b_in`, `res_a` holds the quotient of `a_in` by `b_in` and `res_b` the remainder; both `cy` and `ov` are 0. For example 5Ah by 05h gives 12h remainder 00h.
- R6: A divide with `b_in`=00h completes in the cycle after `start` without raising `busy`: `done`=1, `ov`=1, `cy`=0, `res_a`=`res_b`=FFh.
- R7: Result bytes and flags keep their values from one completion to the next, including all the time `busy` is high.
- R8: A `start` sampled while `busy` is high is ignored: the running operation keeps its operands, its results and its completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | 8 | Multiplicand or dividend |
| b_in | input | 8 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_a | output | 8 | Product low byte or quotient |
| res_b | output | 8 | Product high byte or remainder |
| cy | output | 1 | Carry flag, always cleared |
| ov | output | 1 | Overflow flag |

## Verification
The hardest case to reach from the ports is a second `start` landing in the middle of an iteration. That start carries different operands and a different operation, so if it were wrongly accepted it would corrupt the shifting state. The bench pulses such a start four cycles into a multiply. It then checks that the original product still arrives on the original cycle. Separate runs cover the boundaries: a zero divisor, a divisor larger than the dividend, and a product of exactly FFh against one of 100h.

// File: rtl/byte_muldiv.sv
module byte_muldiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         cy,
  output logic         ov
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi, lo, opb;
  logic [CW-1:0] cnt;
  logic          mode;

  // multiply step: add multiplicand into upper half when lsb set, shift right
  logic [W:0]    sum;
  logic [2*W:0]  mul_cat;
  assign sum     = {1'b0, hi} + (lo[0] ? {1'b0, opb} : '0);
  assign mul_cat = {sum, lo};

  // divide step: restoring trial subtraction of shifted remainder
  logic [W:0]   trial;
  logic         fits;
  assign trial = {hi, lo[W-1]} - {1'b0, opb};
  assign fits  = ~trial[W];

  logic [W-1:0] hi_nx, lo_nx;
  assign hi_nx = mode ? (fits ? trial[W-1:0] : {hi[W-2:0], lo[W-1]}) : mul_cat[2*W:W+1];
  assign lo_nx = mode ? {lo[W-2:0], fits} : mul_cat[W:1];

  assign cy = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      res_a <= '0;
      res_b <= '0;
      ov    <= 1'b0;
      hi    <= '0;
      lo    <= '0;
      opb   <= '0;
      cnt   <= '0;
      mode  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        mode <= op_div;
        opb  <= b_in;
        if (op_div && b_in == '0) begin
          res_a <= '1;
          res_b <= '1;
          ov    <= 1'b1;
          done  <= 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= '0;
          hi   <= '0;
          lo   <= a_in;
        end
      end else if (busy) begin
        hi  <= hi_nx;
        lo  <= lo_nx;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          res_a <= lo_nx;
          res_b <= hi_nx;
          ov    <= mode ? 1'b0 : |hi_nx;
        end
      end
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  p_mul_ov_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode) |-> (ov == (res_b != '0)));
  p_div_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode && opb != '0) |-> (res_b < opb && !ov));
  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_div && b_in == '0) |=> (done && !busy && ov && res_a == '1 && res_b == '1));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(res_a) && $stable(res_b) && $stable(ov)));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != LAST) |=> busy);
endmodule

// File: tb/tb_byte_muldiv.sv
`timescale 1ns/1ps
module tb_byte_muldiv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic busy, done, cy, ov;
  logic [7:0] res_a, res_b;
  int checks = 0, fails = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  byte_muldiv dut (.clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .res_a(res_a),
    .res_b(res_b), .cy(cy), .ov(ov));

  // {op_div, a, b}
  localparam logic [16:0] VEC [12] = '{
    {1'b0, 8'h55, 8'h17}, {1'b0, 8'hFF, 8'hFF}, {1'b0, 8'h00, 8'h9C},
    {1'b0, 8'h0F, 8'h11}, {1'b0, 8'h10, 8'h10}, {1'b0, 8'h01, 8'hFF},
    {1'b1, 8'h5A, 8'h05}, {1'b1, 8'hFF, 8'h01}, {1'b1, 8'h07, 8'h09},
    {1'b1, 8'hFF, 8'hFF}, {1'b1, 8'h64, 8'h07}, {1'b1, 8'h80, 8'h03}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    start = 1'b1; op_div = op; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; a_in = 8'h3C; b_in = 8'hC3;
  endtask

  task automatic expect_result(input logic op, input logic [7:0] a, input logic [7:0] b,
                               input logic inject);
    logic [15:0] prod;
    logic [7:0] ea, eb;
    logic eov;
    logic [7:0] old_a, old_b;
    old_a = res_a; old_b = res_b;
    if (op) begin ea = a / b; eb = a % b; eov = 1'b0; end
    else begin prod = a * b; ea = prod[7:0]; eb = prod[15:8]; eov = prod > 16'hFF; end
    pulse_start(op, a, b);
    chk("R4 busy rises", {31'd0, busy}, 32'd1);
    for (int i = 1; i < 8; i++) begin
      if (inject && i == 3) begin
        start = 1'b1; op_div = ~op; a_in = 8'hE7; b_in = 8'h00;
      end
      @(negedge clk);
      start = 1'b0;
      if (busy !== 1'b1 || done !== 1'b0) chk(inject ? "R8 busy window" : "R4 busy window", {busy, done}, 2'b10);
      if (i == 4) begin
        chk("R7 res_a held while busy", res_a, old_a);
        chk("R7 res_b held while busy", res_b, old_b);
      end
    end
    @(negedge clk);
    chk("R4 done after 8 cycles", {busy, done}, 2'b01);
    chk(op ? "R5 quotient" : "R2 product low", res_a, ea);
    chk(op ? "R5 remainder" : "R2 product high", res_b, eb);
    chk(op ? "R5 ov" : "R3 ov", ov, eov);
    chk(op ? "R5 cy" : "R3 cy", cy, 1'b0);
    @(negedge clk);
    chk("R4 done single pulse", done, 1'b0);
    chk("R7 results hold", {res_a, res_b}, {ea, eb});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, done, cy, ov, res_a, res_b}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, done}, 2'b00);

    foreach (VEC[k]) expect_result(VEC[k][16], VEC[k][15:8], VEC[k][7:0], 1'b0);

    // divide by zero
    pulse_start(1'b1, 8'h42, 8'h00);
    chk("R6 done immediately", {busy, done}, 2'b01);
    chk("R6 all-ones results", {res_a, res_b}, 16'hFFFF);
    chk("R6 ov set", ov, 1'b1);
    chk("R6 cy clear", cy, 1'b0);
    @(negedge clk);
    chk("R6 single pulse", {busy, done}, 2'b00);
    chk("R7 ov holds", ov, 1'b1);

    // a valid divide after div0 clears ov
    expect_result(1'b1, 8'hC8, 8'h0A, 1'b0);
    // start while busy ignored
    expect_result(1'b0, 8'hA5, 8'h3B, 1'b1);
    expect_result(1'b1, 8'hEE, 8'h0D, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule